// File: doc/BRIEF.md
# Five-Phase Nibble Accumulator Processor

This block is a small processor core with 4-bit data that can only add. Each program word is eight bits wide. The upper nibble holds four independent control bits and the lower nibble holds an operand K. Every instruction runs through the same fixed sequence of five clock cycles. The state consists of an 8-bit program counter, a 4-bit data-address register, a 4-bit accumulator, a carry flag and a captured carry. The captured carry is taken from the carry flag at the start of an instruction. Later in the same instruction it can be added either into the accumulator (add with carry) or into the program counter (a conditional skip).

Program memory sits outside the core and is read synchronously. The core drives the address, and the word appears on the read-data input one clock later. Data memory is internal and holds sixteen nibbles. Word 0 always reads as zero, so storing to it clears the accumulator without any other effect. A debug port can read and write the data memory; it is used to preload operands and to observe stored results. The core has no load, no logic operation and no immediate operand. A value enters the accumulator only by adding memory into it.

Top module: `nibble_acc_core`

## Requirements
- R1: A synchronous reset sets the program counter, data-address register, accumulator, carry and captured carry to zero, so `pm_addr` reads 0 after reset and an accumulator stored straight after reset is 0.
- R2: Every instruction takes exactly five clock cycles. The core fetches the word at `pm_addr` in the first cycle of each instruction, and for instructions without the jump bit the next instruction's address is one higher.
- R3: Control bits in the upper nibble are, from bit 7 down to bit 4: store, jump, capture-carry, add-carry. With the store and jump bits clear, the core adds DM[K] into the accumulator modulo 16, and a carry-out sets the carry flag.
- R4: With the store bit set (opcode 1000), the core writes the accumulator to DM[K] in the fifth cycle and then clears the accumulator.
- R5: Data-memory word 0 always reads as zero, and writes to it from the core or the debug port have no effect.
- R6: With the jump bit set (opcode 0100), K is added unsigned to the program counter, which is then incremented. The next address is P+K+1 modulo 256.
- R7: When the capture-carry bit is set, the carry flag is copied into the captured carry and cleared in the second cycle of the instruction.
- R8: Opcode 0011 adds DM[K] and the captured carry into the accumulator.
- R9: Opcode 0111 with K=0 skips the next instruction exactly when the carry flag was set at its start.
- R10: The captured carry is zero at the end of every instruction. When the add-carry bit is clear, its value is discarded.
- R11: With `dbg_we` high, the debug port writes `dbg_wdata` to DM[`dbg_addr`], unless the core stores in that cycle. `dbg_rdata` shows DM[`dbg_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 8 | Program-memory read address (the program counter) |
| pm_rdata | input | 8 | Program word, valid one cycle after its address |
| dbg_we | input | 1 | Debug write enable for data memory |
| dbg_addr | input | 4 | Debug data-memory address |
| dbg_wdata | input | 4 | Debug write data |
| dbg_rdata | output | 4 | Debug read data |

## Verification
The embedded assertions check on every cycle the parts of the five-phase sequence that are structural. They cover the phase wraparound, the program counter holding through fetch and stepping by one in the fourth cycle, the captured carry being empty at each instruction boundary, the address register staying at zero on jumps, the carry capture and the accumulator clearing after a store. The arithmetic results, the conditional skip and the zero word cannot be checked that way. Only the bench's scenarios show them, by running short programs over preloaded operands and reading stored results back through the debug port. Those results include sums with and without carry-out, add-with-carry after an overflow, skips taken and not taken, jump wraparound and stores to word 0.

// File: rtl/nac_pkg.sv
package nac_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        PH1 = 3'd0,
        PH2 = 3'd1,
        PH3 = 3'd2,
        PH4 = 3'd3,
        PH5 = 3'd4
    } phase_e;

    // upper nibble of a program word, bit 3 first
    typedef struct packed {
        logic store;
        logic jump;
        logic grab_cy;
        logic add_cy;
    } ctl_t;

endpackage

// File: rtl/nac_phase.sv
module nac_phase
    import nac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    phase_e ph_d, ph_q;

    always_comb begin
        case (ph_q)
            PH1:     ph_d = PH2;
            PH2:     ph_d = PH3;
            PH3:     ph_d = PH4;
            PH4:     ph_d = PH5;
            default: ph_d = PH1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH1;
        else     ph_q <= ph_d;
    end

    assign phase = ph_q;

    // R2: five cycles per instruction, then back to fetch
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH5) |=> (ph_q == PH1));

endmodule

// File: rtl/nac_dmem.sv
module nac_dmem #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    // core store has priority over the debug port
    always_comb begin
        wr_en   = core_we | dbg_we;
        wr_addr = core_we ? core_addr  : dbg_addr;
        wr_data = core_we ? core_wdata : dbg_wdata;
    end

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr != '0)) mem_q[wr_addr] <= wr_data;
    end

    assign core_rdata = (core_addr == '0) ? '0 : mem_q[core_addr];
    assign dbg_rdata  = (dbg_addr  == '0) ? '0 : mem_q[dbg_addr];

endmodule

// File: rtl/nibble_acc_core.sv
module nibble_acc_core
    import nac_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [PC_W-1:0]      pm_addr,
    input  logic [2*NIB_W-1:0]   pm_rdata,
    input  logic                 dbg_we,
    input  logic [NIB_W-1:0]     dbg_addr,
    input  logic [NIB_W-1:0]     dbg_wdata,
    output logic [NIB_W-1:0]     dbg_rdata
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [NIB_W-1:0] m;
        logic [NIB_W-1:0] acc;
        logic             cy;
        logic             cyc;
        ctl_t             ir;
    } core_st_t;

    core_st_t          st_d, st_q;
    phase_e            phase;
    logic              dm_we;
    logic [NIB_W-1:0]  dm_rdata;
    logic [NIB_W:0]    sum;
    ctl_t              fetched;
    logic [NIB_W-1:0]  k_fld;

    assign fetched = ctl_t'(pm_rdata[2*NIB_W-1:NIB_W]);
    assign k_fld   = pm_rdata[NIB_W-1:0];

    nac_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    nac_dmem #(.AW(NIB_W), .DW(NIB_W)) u_dmem (
        .clk        (clk),
        .core_we    (dm_we),
        .core_addr  (st_q.m),
        .core_wdata (st_q.acc),
        .core_rdata (dm_rdata),
        .dbg_we     (dbg_we),
        .dbg_addr   (dbg_addr),
        .dbg_wdata  (dbg_wdata),
        .dbg_rdata  (dbg_rdata)
    );

    always_comb begin
        st_d  = st_q;
        dm_we = 1'b0;
        sum   = '0;
        case (phase)
            PH1: begin
                st_d.m  = '0;
                st_d.ir = '0;
            end
            PH2: begin
                st_d.ir = fetched;
                if (fetched.grab_cy) begin
                    st_d.cyc = st_q.cy;
                    st_d.cy  = 1'b0;
                end
            end
            PH3: begin
                if (st_q.ir.jump) st_d.pc = st_q.pc + PC_W'(k_fld);
                else              st_d.m  = k_fld;
            end
            PH4: begin
                st_d.pc = st_q.pc + PC_W'(1);
                if (!st_q.ir.store) begin
                    sum       = {1'b0, st_q.acc} + {1'b0, dm_rdata};
                    st_d.acc  = sum[NIB_W-1:0];
                    st_d.cy   = st_q.cy | sum[NIB_W];
                end
            end
            default: begin
                st_d.cyc = 1'b0;
                if (st_q.ir.add_cy) begin
                    if (st_q.ir.jump) begin
                        st_d.pc = st_q.pc + PC_W'(st_q.cyc);
                    end else begin
                        sum      = {1'b0, st_q.acc} + (NIB_W+1)'(st_q.cyc);
                        st_d.acc = sum[NIB_W-1:0];
                        st_d.cy  = st_q.cy | sum[NIB_W];
                    end
                end
                if (st_q.ir.store) begin
                    dm_we    = 1'b1;
                    st_d.acc = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pm_addr = st_q.pc;

    // R10: captured carry is empty at every instruction boundary
    p_cyc_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH1) |-> (st_q.cyc == 1'b0));

    // R2: program counter holds while the word is fetched
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH1 || phase == PH2) |=> $stable(st_q.pc));

    // R2: program counter steps by one in the fourth cycle
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH4) |=> (st_q.pc == $past(st_q.pc) + PC_W'(1)));

    // R6: a jump leaves the address register at zero
    p_jump_m_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH4 && st_q.ir.jump) |-> (st_q.m == '0));

    // R7: carry capture moves CY into CYC and clears CY
    p_grab_cy_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH2 && fetched.grab_cy) |=>
            (st_q.cy == 1'b0 && st_q.cyc == $past(st_q.cy)));

    // R4: a store leaves the accumulator cleared
    p_store_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH5 && st_q.ir.store) |=> (st_q.acc == '0));

endmodule

// File: tb/nibble_acc_core_test.sv
module nibble_acc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // operand pairs {x, y}
    localparam logic [7:0] VEC [NV] = '{8'h34, 8'h97, 8'hFF, 8'h00, 8'h88, 8'h1E};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pm_addr;
    logic [7:0] pm_rdata = 8'h00;
    logic       dbg_we = 1'b0;
    logic [3:0] dbg_addr = 4'h0;
    logic [3:0] dbg_wdata = 4'h0;
    logic [3:0] dbg_rdata;
    logic [7:0] pm [256];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) pm_rdata <= pm[pm_addr];

    nibble_acc_core uut (
        .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic fill_pm(input logic [7:0] w);
        for (int i = 0; i < 256; i++) pm[i] = w;
    endtask

    task automatic dm_wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic dm_rd(input logic [3:0] a, output logic [3:0] d);
        dbg_addr = a;
        #1;
        d = dbg_rdata;
    endtask

    task automatic hold_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic release_run(input int n);
        @(negedge clk);
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] rd;
        logic [3:0] x, y;
        int s;
        fill_pm(8'h00);

        // R1: reset state; store right after reset writes accumulator 0
        hold_reset();
        check("R1 pm_addr in reset", pm_addr, 0);
        pm[0] = 8'h83;
        dm_wr(4'd3, 4'd9);
        release_run(10);
        dm_rd(4'd3, rd);
        check("R1 acc zero after reset", rd, 0);

        // R2: five cycles per instruction (no-op program)
        fill_pm(8'h00);
        hold_reset();
        release_run(3);
        check("R2 pm_addr mid instruction", pm_addr, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 pm_addr next instruction", pm_addr, 1);
        hold_reset();
        check("R1 pm_addr after re-reset", pm_addr, 0);

        // main vector table: ADM1 ADM2 STM3 SKC ADM5 STM6
        for (int v = 0; v < NV; v++) begin
            fill_pm(8'h00);
            pm[0] = 8'h21; pm[1] = 8'h22; pm[2] = 8'h83;
            pm[3] = 8'h70; pm[4] = 8'h25; pm[5] = 8'h86;
            x = VEC[v][7:4]; y = VEC[v][3:0];
            hold_reset();
            dm_wr(4'd1, x); dm_wr(4'd2, y); dm_wr(4'd3, 4'd0);
            dm_wr(4'd5, 4'd1); dm_wr(4'd6, 4'd9);
            release_run(40);
            s = int'(x) + int'(y);
            dm_rd(4'd3, rd);
            check("R3 R4 sum stored", rd, s % 16);
            dm_rd(4'd6, rd);
            check("R9 skip on carry", rd, (s > 15) ? 0 : 1);
        end

        // R8: add with captured carry after overflow
        fill_pm(8'h00);
        pm[0] = 8'h21; pm[1] = 8'h22; pm[2] = 8'h33; pm[3] = 8'h84;
        hold_reset();
        dm_wr(4'd1, 4'd15); dm_wr(4'd2, 4'd1); dm_wr(4'd3, 4'd5); dm_wr(4'd4, 4'd9);
        release_run(30);
        dm_rd(4'd4, rd);
        check("R8 acm adds carry", rd, 6);

        // R10 / R7: capture without add discards carry and clears CY
        fill_pm(8'h00);
        pm[0] = 8'h21; pm[1] = 8'h22; pm[2] = 8'h23; pm[3] = 8'h84;
        pm[4] = 8'h70; pm[5] = 8'h27; pm[6] = 8'h88;
        hold_reset();
        dm_wr(4'd4, 4'd9); dm_wr(4'd7, 4'd1); dm_wr(4'd8, 4'd9);
        release_run(45);
        dm_rd(4'd4, rd);
        check("R10 carry discarded", rd, 5);
        dm_rd(4'd8, rd);
        check("R7 cy cleared so no skip", rd, 1);

        // R5 / R4: store to word 0 clears acc; word 0 stays zero
        fill_pm(8'h00);
        pm[0] = 8'h21; pm[1] = 8'h80; pm[2] = 8'h20; pm[3] = 8'h87;
        hold_reset();
        dm_wr(4'd1, 4'd7); dm_wr(4'd7, 4'd9); dm_wr(4'd0, 4'd5);
        dm_rd(4'd0, rd);
        check("R5 debug write to word 0 ignored", rd, 0);
        release_run(30);
        dm_rd(4'd7, rd);
        check("R4 store 0 clears acc", rd, 0);
        dm_rd(4'd0, rd);
        check("R5 word 0 after core store", rd, 0);

        // R11: debug port write and read back
        dm_wr(4'd9, 4'hA);
        dm_rd(4'd9, rd);
        check("R11 debug readback", rd, 10);

        // R6: relative jump P+K+1
        fill_pm(8'h00);
        pm[0] = 8'h45;
        hold_reset();
        release_run(5);
        check("R6 jump target", pm_addr, 6);

        // R6: jump by 15 repeatedly wraps the 8-bit counter
        fill_pm(8'h4F);
        hold_reset();
        release_run(40);
        check("R6 eight jumps", pm_addr, 128);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R6 wrap to zero", pm_addr, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule